// File: doc/BRIEF.md
# Serial Quad Wiper Register Controller

This block is the digital core of a four-channel programmable voltage source. A host reaches it over a three-wire serial port (serial clock, data in, data out) framed by an active-high chip select. Each channel has two 8-bit codes. The working code drives the channel's output code. The stored code is a modeled non-volatile copy. The host can set a working code to try out a value, read either copy back, or save a working code into storage. A save runs a counted erase/write period, and the ready/busy output is low for that whole period.

The serial inputs may be asynchronous to the core clock. A two-flop synchronizer brings them in, and a rising-edge detector turns each serial clock rise into a single-cycle event. The frame state machine has these states:

- `S_HUNT`: waits for a start bit.
- `S_OPCODE`: collects the operation.
- `S_CHAN`: collects the channel number.
- `S_DATA`: collects a write value.
- `S_SHIFT`: sends read data.
- `S_TAIL`: ignores everything until chip select falls.

The transitions are:

- `S_HUNT`→`S_OPCODE` when a 1 is sampled.
- `S_OPCODE`→`S_CHAN` after 2 bits.
- `S_CHAN`→`S_DATA` for a set-working command, →`S_SHIFT` for either read, and →`S_TAIL` for a save or for any command while busy.
- `S_DATA`→`S_TAIL` and `S_SHIFT`→`S_TAIL` after 8 bits.
- Any state→`S_HUNT` when chip select is low.

At reset every working code is reloaded from its stored code. The storage flops are not reset; they take the `STORE_INIT` value only at configuration. The tri-state data output is given as a data/enable pair.

Top module: `serial_wiper_ctrl`

## Requirements
- R1: While reset is asserted, and after it, every output code equals the stored code of its channel. After reset `rdy_bsy` is 1.
- R2: A frame is a 1 start bit, then a 2-bit operation, then a 2-bit channel, then, for a set, 8 data bits. All fields are sent MSB first, and `di` is sampled on rising `sclk` edges. Zeros sampled before the start bit are skipped.
- R3: Operation 00 (set working) loads the 8 data bits into the addressed channel's working code once the last data bit is sampled. Other channels and all stored codes stay unchanged.
- R4: Operation 01 (read working) and operation 10 (read stored) put the 8-bit value on `do_data`, MSB first. The MSB appears after the rise that samples the last channel bit, and each following rise presents the next bit. Output codes do not change.
- R5: `do_oe` is high while `cs` is high and low while `cs` is low. `do_data` is 0 outside read data.
- R6: Operation 11 (save) with `prog` high, not busy and `low_vdd` low drives `rdy_bsy` low for exactly `BUSY_CYCLES` clock cycles. At the end, the addressed stored code takes the working value it had when the save was accepted.
- R7: A save with `prog` low, or with `low_vdd` high, is ignored. `rdy_bsy` stays high and storage is unchanged.
- R8: If `low_vdd` is high in the last busy cycle, storage is not written, and `rdy_bsy` still returns high on time.
- R9: While busy, every command is ignored. A set changes nothing, and a read returns all zeros.
- R10: A frame cut short by `cs` falling has no effect.
- R11: Each new rise of `cs` starts a new frame, so a complete frame after an aborted one takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset; restores working codes |
| sclk | input | 1 | Serial clock |
| cs | input | 1 | Active-high chip select |
| di | input | 1 | Serial data in |
| prog | input | 1 | Program enable for saves |
| low_vdd | input | 1 | Low-supply indication; blocks storage writes |
| do_data | output | 1 | Serial data out |
| do_oe | output | 1 | Drive enable for `do_data` (low = high impedance) |
| rdy_bsy | output | 1 | 1 = ready, 0 = erase/write in progress |
| wiper_codes | output | NCH*W | Working codes, channel 0 in the low byte |

## Verification
A save can reach the end of its busy count in the same cycle that the supply-low input is high. The bench provokes this by raising `low_vdd` partway through a save and holding it until ready returns. It then judges two things: that the busy length is still exactly `BUSY_CYCLES`, and that a read-stored frame returns the old value. The bench also sends set-working and read frames while a save is counting. It checks that the output codes stay frozen, that reads return zeros, and that the save commits its value as latched at acceptance.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_SET_WORK  = 2'b00,
        OP_GET_WORK  = 2'b01,
        OP_GET_STORE = 2'b10,
        OP_SAVE      = 2'b11
    } wpr_op_e;

    typedef enum logic [2:0] {
        S_HUNT,
        S_OPCODE,
        S_CHAN,
        S_DATA,
        S_SHIFT,
        S_TAIL
    } wpr_state_e;

endpackage

// File: rtl/wpr_sync.sv
module wpr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_i,
    input  logic di_i,
    output logic cs_s,
    output logic di_s,
    output logic sclk_rise
);

    logic [STAGES-1:0] sclk_p, cs_p, di_p;
    logic              sclk_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p <= '0;
            cs_p   <= '0;
            di_p   <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_p <= {sclk_p[STAGES-2:0], sclk_i};
            cs_p   <= {cs_p[STAGES-2:0], cs_i};
            di_p   <= {di_p[STAGES-2:0], di_i};
            sclk_d <= sclk_p[STAGES-1];
        end
    end

    assign cs_s      = cs_p[STAGES-1];
    assign di_s      = di_p[STAGES-1];
    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_d & cs_s;

endmodule

// File: rtl/wpr_frame_fsm.sv
module wpr_frame_fsm
    import wpr_pkg::*;
#(
    parameter int W      = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              di_s,
    input  logic              rise,
    input  logic              busy,
    input  logic [W-1:0]      rd_word,
    output logic [ADDR_W-1:0] req_addr,
    output logic              rd_stored,
    output logic              wr_req,
    output logic              save_req,
    output logic [W-1:0]      wr_data,
    output logic              do_bit
);

    localparam int CNT_W = $clog2(W) + 1;

    wpr_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [OP_W-1:0]   opc_q;
    logic [ADDR_W-1:0] addr_q, addr_full;
    logic [W-1:0]      data_q, shreg_q;
    logic              last_chan, is_read, load_rd;

    assign addr_full = ADDR_W'({addr_q, di_s});
    assign is_read   = (opc_q == OP_GET_WORK) || (opc_q == OP_GET_STORE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!cs_s) begin
            state_d = S_HUNT;
        end else if (rise) begin
            unique case (state_q)
                S_HUNT:   if (di_s) state_d = S_OPCODE;
                S_OPCODE: if (cnt_q == CNT_W'(OP_W-1)) state_d = S_CHAN;
                S_CHAN: begin
                    if (cnt_q == CNT_W'(ADDR_W-1)) begin
                        if (busy)                       state_d = S_TAIL;
                        else if (opc_q == OP_SET_WORK)  state_d = S_DATA;
                        else if (is_read)               state_d = S_SHIFT;
                        else                            state_d = S_TAIL;
                    end
                end
                S_DATA:   if (cnt_q == CNT_W'(W-1)) state_d = S_TAIL;
                S_SHIFT:  if (cnt_q == CNT_W'(W-1)) state_d = S_TAIL;
                S_TAIL:   state_d = S_TAIL;
                default:  state_d = S_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_HUNT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        last_chan = rise && cs_s && (state_q == S_CHAN) && (cnt_q == CNT_W'(ADDR_W-1));
        wr_req    = rise && cs_s && (state_q == S_DATA) && (cnt_q == CNT_W'(W-1));
        save_req  = last_chan && !busy && (opc_q == OP_SAVE);
        load_rd   = last_chan && !busy && is_read;
        req_addr  = last_chan ? addr_full : addr_q;
        rd_stored = (opc_q == OP_GET_STORE);
        wr_data   = W'({data_q, di_s});
        do_bit    = shreg_q[W-1];
    end

    // field shifters
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_s) begin
            cnt_q   <= '0;
            opc_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            shreg_q <= '0;
        end else if (rise) begin
            cnt_q <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            if (state_q == S_OPCODE) opc_q  <= OP_W'({opc_q, di_s});
            if (state_q == S_CHAN)   addr_q <= addr_full;
            if (state_q == S_DATA)   data_q <= wr_data;
            if (load_rd)                  shreg_q <= rd_word;
            else if (state_q == S_SHIFT)  shreg_q <= {shreg_q[W-2:0], 1'b0};
        end
    end

    a_r10_abort_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> state_q == S_HUNT);

    a_r4_shift_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SHIFT) && cs_s && !rise |=> state_q == S_SHIFT);

    a_r2_hunt_skips_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HUNT) && rise && !di_s |=> state_q == S_HUNT);

endmodule

// File: rtl/wpr_wiper_bank.sv
module wpr_wiper_bank #(
    parameter int         NCH         = 4,
    parameter int         W           = 8,
    parameter int         BUSY_CYCLES = 400000,
    parameter logic [W-1:0] STORE_INIT = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_req,
    input  logic                      save_req,
    input  logic [$clog2(NCH)-1:0]    req_addr,
    input  logic [W-1:0]              wr_data,
    input  logic                      rd_stored,
    input  logic                      prog,
    input  logic                      low_vdd,
    output logic                      busy,
    output logic [W-1:0]              rd_word,
    output logic [NCH*W-1:0]          wiper_codes
);

    localparam int ADDR_W = $clog2(NCH);
    localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);

    logic [W-1:0]      work_q [NCH];
    logic [W-1:0]      nv_q   [NCH] = '{default: STORE_INIT};
    logic [NCH*W-1:0]  nv_flat;
    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] sv_addr_q;
    logic [W-1:0]      sv_val_q;
    logic              wr_go, save_go, commit;

    assign wr_go   = wr_req & ~busy_q;
    assign save_go = save_req & ~busy_q & prog & ~low_vdd;
    assign commit  = busy_q && (cnt_q == '0) && !low_vdd;

    // erase/write timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            sv_addr_q <= '0;
            sv_val_q  <= '0;
        end else if (save_go) begin
            busy_q    <= 1'b1;
            cnt_q     <= CNT_W'(BUSY_CYCLES - 1);
            sv_addr_q <= req_addr;
            sv_val_q  <= work_q[req_addr];
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n)
                work_q[g] <= nv_q[g];
            else if (wr_go && req_addr == ADDR_W'(g))
                work_q[g] <= wr_data;
        end

        always_ff @(posedge clk) begin
            if (commit && sv_addr_q == ADDR_W'(g))
                nv_q[g] <= sv_val_q;
        end

        assign wiper_codes[g*W +: W] = work_q[g];
        assign nv_flat[g*W +: W]     = nv_q[g];
    end

    assign busy    = busy_q;
    assign rd_word = rd_stored ? nv_q[req_addr] : work_q[req_addr];

    a_r3_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |=> $stable(nv_flat));

    a_r9_work_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(wiper_codes));

    a_r7_save_gated: assert property (@(posedge clk) disable iff (!rst_n)
        save_req && !busy_q && (!prog || low_vdd) |=> !busy_q);

    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && (cnt_q != '0) |=> busy_q);

    a_r8_low_supply_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && low_vdd |=> $stable(nv_flat));

endmodule

// File: rtl/serial_wiper_ctrl.sv
module serial_wiper_ctrl #(
    parameter int           NCH         = 4,
    parameter int           W           = 8,
    parameter int           SYNC_STAGES = 2,
    parameter int           BUSY_CYCLES = 400000,
    parameter logic [W-1:0] STORE_INIT  = 8'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs,
    input  logic             di,
    input  logic             prog,
    input  logic             low_vdd,
    output logic             do_data,
    output logic             do_oe,
    output logic             rdy_bsy,
    output logic [NCH*W-1:0] wiper_codes
);

    localparam int ADDR_W = $clog2(NCH);

    logic              cs_s, di_s, rise, busy;
    logic [W-1:0]      rd_word, wr_data;
    logic [ADDR_W-1:0] req_addr;
    logic              rd_stored, wr_req, save_req, do_bit;

    wpr_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .cs_i      (cs),
        .di_i      (di),
        .cs_s      (cs_s),
        .di_s      (di_s),
        .sclk_rise (rise)
    );

    wpr_frame_fsm #(.W(W), .ADDR_W(ADDR_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .di_s      (di_s),
        .rise      (rise),
        .busy      (busy),
        .rd_word   (rd_word),
        .req_addr  (req_addr),
        .rd_stored (rd_stored),
        .wr_req    (wr_req),
        .save_req  (save_req),
        .wr_data   (wr_data),
        .do_bit    (do_bit)
    );

    wpr_wiper_bank #(
        .NCH         (NCH),
        .W           (W),
        .BUSY_CYCLES (BUSY_CYCLES),
        .STORE_INIT  (STORE_INIT)
    ) i_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_req      (wr_req),
        .save_req    (save_req),
        .req_addr    (req_addr),
        .wr_data     (wr_data),
        .rd_stored   (rd_stored),
        .prog        (prog),
        .low_vdd     (low_vdd),
        .busy        (busy),
        .rd_word     (rd_word),
        .wiper_codes (wiper_codes)
    );

    assign do_oe   = cs_s;
    assign do_data = cs_s & do_bit;
    assign rdy_bsy = ~busy;

    a_r5_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !do_oe |-> !do_data);

endmodule

// File: tb/test_serial_wiper_ctrl.sv
module test_serial_wiper_ctrl;

    localparam int         NCH  = 4;
    localparam int         W    = 8;
    localparam int         BUSY = 600;
    localparam int         HALF = 4;
    localparam logic [7:0] INIT = 8'h5A;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs = 1'b0, di = 1'b0;
    logic prog = 1'b0, low_vdd = 1'b0;
    logic do_data, do_oe, rdy_bsy;
    logic [NCH*W-1:0] wipers;

    int  vec = 0, bad = 0, low_cnt = 0;
    bit  done = 1'b0;
    logic [7:0] exp_work [NCH];
    logic [7:0] exp_store [NCH];

    always #5 clk = ~clk;

    serial_wiper_ctrl #(
        .NCH(NCH), .W(W), .BUSY_CYCLES(BUSY), .STORE_INIT(INIT)
    ) i_serial_wiper_ctrl (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs(cs), .di(di),
        .prog(prog), .low_vdd(low_vdd), .do_data(do_data), .do_oe(do_oe),
        .rdy_bsy(rdy_bsy), .wiper_codes(wipers)
    );

    always @(negedge clk) if (rst_n && !rdy_bsy) low_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [1:0] op, input int ch, input logic [7:0] data,
                         input int nrise, input int lead, output logic [7:0] rd);
        logic [12:0] bits;
        bits = {1'b1, op, ch[1:0], data};
        rd   = '0;
        cs   = 1'b1;
        wait_clk(HALF);
        for (int i = 0; i < lead + nrise; i++) begin
            di = (i < lead) ? 1'b0 : bits[12 - (i - lead)];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
            wait_clk(HALF);
            if (i - lead >= 4 && i - lead <= 11) rd[11 - (i - lead)] = do_data;
        end
        cs = 1'b0;
        di = 1'b0;
        wait_clk(HALF * 2);
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < NCH; c++) chk(req, 32'(wipers[c*W +: W]), 32'(exp_work[c]));
    endtask

    task automatic read_chk(input logic [1:0] op, input int ch, input string req);
        logic [7:0] rd;
        frame(op, ch, 8'h00, 13, 0, rd);
        chk(req, 32'(rd), (op == 2'b10) ? 32'(exp_store[ch]) : 32'(exp_work[ch]));
    endtask

    initial begin
        logic [7:0] rd;
        logic [7:0] saved;
        for (int c = 0; c < NCH; c++) begin
            exp_work[c]  = INIT;
            exp_store[c] = INIT;
        end
        wait_clk(5);
        check_all("R1 during reset");
        rst_n = 1'b1;
        wait_clk(4);
        check_all("R1");
        chk("R1 ready", 32'(rdy_bsy), 32'd1);
        chk("R5 deselected oe", 32'(do_oe), 32'd0);

        // R5: enable follows chip select
        cs = 1'b1; wait_clk(6);
        chk("R5 selected oe", 32'(do_oe), 32'd1);
        chk("R5 idle data", 32'(do_data), 32'd0);
        cs = 1'b0; wait_clk(6);
        chk("R5 released oe", 32'(do_oe), 32'd0);

        // R3/R4 sweep of set-working and read-working over all channels
        for (int k = 0; k < 16; k++) begin
            for (int c = 0; c < NCH; c++) begin
                logic [7:0] v;
                v = 8'((k * 17 + c * 5 + k * c) & 255);
                frame(2'b00, c, v, 13, 0, rd);
                exp_work[c] = v;
                check_all("R3");
                read_chk(2'b01, c, "R4 read working");
                check_all("R4 outputs untouched");
            end
        end

        // R4: stored values untouched by working writes
        for (int c = 0; c < NCH; c++) read_chk(2'b10, c, "R4 read stored");
        check_all("R4 outputs after stored reads");

        // R2: leading zeros before start bit
        frame(2'b00, 2, 8'hC3, 13, 3, rd);
        exp_work[2] = 8'hC3;
        check_all("R2 leading zeros");

        // R10: truncated frame, then R11 full frame
        frame(2'b00, 1, 8'h11, 12, 0, rd);
        check_all("R10 truncated");
        frame(2'b00, 1, 8'h11, 13, 0, rd);
        exp_work[1] = 8'h11;
        check_all("R11 restart");

        // R7: save without prog, then with low supply
        low_cnt = 0;
        frame(2'b11, 0, 8'h00, 13, 0, rd);
        wait_clk(20);
        chk("R7 no prog busy", 32'(low_cnt), 32'd0);
        read_chk(2'b10, 0, "R7 no prog store");
        prog = 1'b1; low_vdd = 1'b1;
        frame(2'b11, 0, 8'h00, 13, 0, rd);
        wait_clk(20);
        chk("R7 low supply busy", 32'(low_cnt), 32'd0);
        low_vdd = 1'b0;
        read_chk(2'b10, 0, "R7 low supply store");

        // R6 save with R9 commands during busy
        low_cnt = 0;
        saved = exp_work[3];
        frame(2'b11, 3, 8'h00, 13, 0, rd);
        chk("R6 busy low", 32'(rdy_bsy), 32'd0);
        frame(2'b00, 3, 8'hE7, 13, 0, rd);
        check_all("R9 set ignored");
        frame(2'b01, 3, 8'h00, 13, 0, rd);
        chk("R9 read zero", 32'(rd), 32'd0);
        while (!rdy_bsy) wait_clk(1);
        prog = 1'b0;
        chk("R6 busy length", 32'(low_cnt), 32'(BUSY));
        exp_store[3] = saved;
        read_chk(2'b10, 3, "R6 stored value");
        frame(2'b00, 3, 8'h01, 13, 0, rd);
        exp_work[3] = 8'h01;
        check_all("R3 trial write");
        read_chk(2'b10, 3, "R3 stored kept");

        // R8: low supply at end of busy
        prog = 1'b1; low_cnt = 0;
        frame(2'b11, 2, 8'h00, 13, 0, rd);
        wait_clk(50);
        low_vdd = 1'b1;
        while (!rdy_bsy) wait_clk(1);
        low_vdd = 1'b0; prog = 1'b0;
        chk("R8 busy length", 32'(low_cnt), 32'(BUSY));
        read_chk(2'b10, 2, "R8 store unchanged");

        // R1: restore on reset
        for (int c = 0; c < NCH; c++) begin
            frame(2'b00, c, 8'(8'hF0 + c), 13, 0, rd);
            exp_work[c] = 8'(8'hF0 + c);
        end
        check_all("R1 pre-reset");
        rst_n = 1'b0; wait_clk(3);
        rst_n = 1'b1; wait_clk(3);
        for (int c = 0; c < NCH; c++) exp_work[c] = exp_store[c];
        check_all("R1 restore");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

endmodule